// File: doc/BRIEF.md
# Cascadable Serial Control Port

This block is the digital serial port of one channel in a daisy chain of codec channels. Words of 16 bits arrive MSB first on a serial data input, each announced by a one-clock input frame pulse. Once a word is complete, the port decides what it is. It may be converter data for the DAC, a register write for this channel, a readback request for this channel, or a control word meant for a channel further down the chain. Words that travel on leave through the serial output with their own one-clock output frame pulse. The output pins of one channel wire straight to the input pins of the next.

A control word carries a 3-bit hop address. Zero means "this channel". Any other value is decremented by one and the word is passed on, so the host reaches the n-th channel by sending address n-1. In mixed mode the MSB tells data (0) from control (1). Outside mixed mode every word is control. DAC data is not applied on arrival. The channel counts DAC frames until the count equals the programmed device count, and only then latches the word into its DAC register. On every DAC frame it hands the DAC word it held before downstream, so a chain of N channels loaded with N words leaves each channel holding its own word.

Top module: `casc_sport`

## Requirements
- R1: After reset the mode register reads 8'h01, the clock and power registers read 8'h00, the DAC word is zero, and the serial output and output frame pulse are low.
- R2: A word is framed by `fs_in` high for one clock, followed by 16 data bits MSB first on the next 16 clocks. A register write is visible 18 clocks after the clock in which `fs_in` was high. An outgoing word raises `fs_out` 19 clocks after that clock, for one clock. Its MSB follows on `ser_out` in the next clock.
- R3: A control word with address field (bits 13:11) equal to zero and bit 14 clear writes bits 7:0 into the register chosen by bits 10:8 (0 = mode, 1 = clock, 2 = power; other values write nothing) and produces no outgoing word.
- R4: A control word with a non-zero address field goes out unchanged except for its address field, which is decremented by one. This channel's registers do not change.
- R5: A control word with address zero and bit 14 set goes out with address field 3'b111 and bits 7:0 replaced by the selected register (zero for an unused select), and changes no register. A readback word with a non-zero address is only forwarded per R4.
- R6: Mixed mode holds only while mode bits 7 and 6 are both one. Outside mixed mode a word with MSB 0 is decoded as control.
- R7: In mixed mode, a word with MSB 0 is a DAC frame. The channel counts DAC frames. On the frame that makes the count equal to mode bits 2:0 (0 counts as 8), it loads the word into `dac_word`, pulses `dac_strobe` for one clock and clears the count.
- R8: Every DAC frame sends downstream the DAC word received on the previous DAC frame (zero after reset).
- R9: Control words do not advance or clear the DAC frame count.
- R10: `fs_in` pulses while a word is still being shifted in are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data in, MSB first |
| fs_in | input | 1 | Input frame pulse, one clock before the first bit |
| ser_out | output | 1 | Serial data out, MSB first |
| fs_out | output | 1 | Output frame pulse, one clock before the first bit |
| dac_word | output | 16 | Word last latched for the DAC |
| dac_strobe | output | 1 | One-clock pulse when `dac_word` loads |
| reg_mode | output | 8 | Mode register: bit 7 program/data, bit 6 mixed enable, bits 2:0 device count |
| reg_clk | output | 8 | Clock and rate configuration register |
| reg_pwr | output | 8 | Power-up enable register |

## Verification
The bench walks the hop address through every non-zero value and checks the decrement. A port that compared against the wrong value or forgot to decrement would either swallow words or send them round the chain forever. Readback at address zero must come out as 3'b111. A port that does not wrap the address, or that forwards instead of answering, gives the wrong field or stale data. Every device count from 1 to 8 is swept, including the field value 0. An off-by-one compare, or a count that control words can advance, strobes the DAC one frame early or late. Further tests cover MSB-0 words outside mixed mode, a mode with only one of the two mode bits set, and a stray frame pulse in mid-word. Each would be wrongly taken as DAC data or a fresh word by a careless decoder.

// File: rtl/casc_sport_pkg.sv
`timescale 1ns/1ps
package casc_sport_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 3;
  localparam int REG_W    = 8;
  localparam int CNT_W    = 3;
  localparam int NUM_REGS = 3;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // register indices
  localparam int MODE_IDX = 0;
  localparam int CLK_IDX  = 1;
  localparam int PWR_IDX  = 2;

  // mode register layout
  localparam int MODE_PD_BIT = 7;
  localparam int MODE_MM_BIT = 6;
  localparam logic [REG_W-1:0] MODE_RESET = 8'h01;

  // packed layout, MSB first on the wire
  typedef struct packed {
    logic              ctrl;
    logic              rdbk;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [REG_W-1:0]  data;
  } cword_t;
endpackage

// File: rtl/casc_sport_rx.sv
`timescale 1ns/1ps
// Deserializer: one frame pulse, then W bits MSB first.
module casc_sport_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_in,
  input  logic         fs_in,
  output logic [W-1:0] word,
  output logic         valid
);
  localparam int CW = $clog2(W);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (busy) begin
        word <= {word[W-2:0], ser_in};
        cnt  <= cnt + CW'(1);
        if (cnt == CW'(W-1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end else if (fs_in) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/casc_sport_tx.sv
`timescale 1ns/1ps
// Serializer: frame pulse in the load cycle, bits MSB first afterwards.
module casc_sport_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         ser_out,
  output logic         fs_out
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      left    <= '0;
      ser_out <= 1'b0;
      fs_out  <= 1'b0;
    end else begin
      fs_out <= load;
      if (load) begin
        sh      <= word;
        left    <= LW'(W);
        ser_out <= 1'b0;
      end else if (left != '0) begin
        ser_out <= sh[W-1];
        sh      <= {sh[W-2:0], 1'b0};
        left    <= left - LW'(1);
      end else begin
        ser_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/casc_sport_ctrl.sv
`timescale 1ns/1ps
// Word decoder: registers, hop forwarding, readback, DAC frame counting.
module casc_sport_ctrl
  import casc_sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              launch,
  output logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_strobe,
  output logic [REG_W-1:0]  reg_mode,
  output logic [REG_W-1:0]  reg_clk,
  output logic [REG_W-1:0]  reg_pwr
);
  logic [REG_W-1:0]  regf [NUM_REGS];
  logic [WORD_W-1:0] held;
  logic [CNT_W-1:0]  dac_cnt;

  cword_t           w, out_w;
  logic             mixed, is_dac, mine, sel_ok, last_frame;
  logic [REG_W-1:0] rd_val;
  logic [CNT_W-1:0] dev_cnt;

  assign w          = cword_t'(rx_word);
  assign mixed      = regf[MODE_IDX][MODE_PD_BIT] & regf[MODE_IDX][MODE_MM_BIT];
  assign is_dac     = mixed & ~w.ctrl;
  assign mine       = (w.addr == '0);
  assign sel_ok     = (w.sel < SEL_W'(NUM_REGS));
  assign rd_val     = sel_ok ? regf[w.sel[IDX_W-1:0]] : '0;
  assign dev_cnt    = regf[MODE_IDX][CNT_W-1:0];
  // field value 0 wraps to 2**CNT_W frames
  assign last_frame = (dac_cnt == dev_cnt - CNT_W'(1));

  always_comb begin
    out_w      = w;
    out_w.addr = w.addr - ADDR_W'(1);
    if (mine && w.rdbk) out_w.data = rd_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      launch     <= 1'b0;
      tx_word    <= '0;
      held       <= '0;
      dac_word   <= '0;
      dac_strobe <= 1'b0;
      dac_cnt    <= '0;
      for (int i = 0; i < NUM_REGS; i++) regf[i] <= '0;
      regf[MODE_IDX] <= MODE_RESET;
    end else begin
      launch     <= 1'b0;
      dac_strobe <= 1'b0;
      if (valid) begin
        if (is_dac) begin
          launch  <= 1'b1;
          tx_word <= held;
          held    <= rx_word;
          if (last_frame) begin
            dac_word   <= rx_word;
            dac_strobe <= 1'b1;
            dac_cnt    <= '0;
          end else begin
            dac_cnt <= dac_cnt + CNT_W'(1);
          end
        end else if (!mine || w.rdbk) begin
          launch  <= 1'b1;
          tx_word <= out_w;
        end else if (sel_ok) begin
          regf[w.sel[IDX_W-1:0]] <= w.data;
        end
      end
    end
  end

  assign reg_mode = regf[MODE_IDX];
  assign reg_clk  = regf[CLK_IDX];
  assign reg_pwr  = regf[PWR_IDX];
endmodule

// File: rtl/casc_sport.sv
`timescale 1ns/1ps
module casc_sport
  import casc_sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              fs_in,
  output logic              ser_out,
  output logic              fs_out,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_strobe,
  output logic [REG_W-1:0]  reg_mode,
  output logic [REG_W-1:0]  reg_clk,
  output logic [REG_W-1:0]  reg_pwr
);
  logic [WORD_W-1:0] rx_word, tx_word;
  logic              rx_valid, launch;

  casc_sport_rx #(.W(WORD_W)) rx_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .fs_in(fs_in),
    .word(rx_word), .valid(rx_valid)
  );

  casc_sport_ctrl ctrl_i (
    .clk(clk), .rst(rst), .valid(rx_valid), .rx_word(rx_word),
    .launch(launch), .tx_word(tx_word),
    .dac_word(dac_word), .dac_strobe(dac_strobe),
    .reg_mode(reg_mode), .reg_clk(reg_clk), .reg_pwr(reg_pwr)
  );

  casc_sport_tx #(.W(WORD_W)) tx_i (
    .clk(clk), .rst(rst), .load(launch), .word(tx_word),
    .ser_out(ser_out), .fs_out(fs_out)
  );
endmodule

// File: rtl/casc_sport_chk.sv
`timescale 1ns/1ps
module casc_sport_chk
  import casc_sport_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              fs_out,
  input logic              dac_strobe,
  input logic [WORD_W-1:0] dac_word,
  input logic [REG_W-1:0]  reg_mode,
  input logic [REG_W-1:0]  reg_clk,
  input logic [REG_W-1:0]  reg_pwr
);
  p_fs_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fs_out |=> !fs_out);

  p_fs_after_word_r4: assert property (@(posedge clk) disable iff (rst)
    fs_out |-> $past(rx_valid, 2));

  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    dac_strobe |=> !dac_strobe);

  p_dac_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !dac_strobe |-> $stable(dac_word));

  p_regs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_valid) |-> ($stable(reg_mode) && $stable(reg_clk) && $stable(reg_pwr)));
endmodule

bind casc_sport casc_sport_chk chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .fs_out(fs_out),
  .dac_strobe(dac_strobe), .dac_word(dac_word),
  .reg_mode(reg_mode), .reg_clk(reg_clk), .reg_pwr(reg_pwr)
);

// File: tb/casc_sport_tb_top.sv
`timescale 1ns/1ps
module casc_sport_tb_top;
  logic        clk = 1'b0, rst = 1'b1, ser_in = 1'b0, fs_in = 1'b0;
  logic        ser_out, fs_out, dac_strobe;
  logic [15:0] dac_word;
  logic [7:0]  reg_mode, reg_clk, reg_pwr;

  casc_sport dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .fs_in(fs_in),
    .ser_out(ser_out), .fs_out(fs_out),
    .dac_word(dac_word), .dac_strobe(dac_strobe),
    .reg_mode(reg_mode), .reg_clk(reg_clk), .reg_pwr(reg_pwr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc++;

  // downstream receiver model
  int          mon_left = 0, frames = 0, fs_high = 0, strobes = 0;
  int unsigned fs_seen = 0, sent_cyc = 0;
  logic [15:0] mon_sh = '0, last_word = '0;
  always @(negedge clk) begin
    if (mon_left > 0) begin
      mon_sh = {mon_sh[14:0], ser_out};
      mon_left--;
      if (mon_left == 0) begin
        last_word = mon_sh;
        frames++;
      end
    end
    if (fs_out) begin
      mon_left = 16;
      fs_seen  = cyc;
      fs_high++;
    end
    if (dac_strobe) strobes++;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic [15:0] w, input bit glitch);
    @(negedge clk);
    fs_in    = 1'b1;
    sent_cyc = cyc;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      fs_in  = glitch && (i == 8);
      ser_in = w[i];
    end
    @(negedge clk);
    ser_in = 1'b0;
    fs_in  = 1'b0;
  endtask

  task automatic idle();
    repeat (40) @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] fwd(input logic [15:0] w);
    return {w[15:14], w[13:11] - 3'd1, w[10:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [7:0]  d_list [3];
    logic [23:0] snap;
    logic [15:0] w;
    int          f0, s0;
    d_list[0] = 8'h00; d_list[1] = 8'h3C; d_list[2] = 8'hFF;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(reg_mode == 8'h01, "R1 mode reset", reg_mode, 8'h01);
    chk(reg_clk == 8'h00 && reg_pwr == 8'h00, "R1 clk/pwr reset", {reg_clk, reg_pwr}, 0);
    chk(dac_word == 16'h0 && !ser_out && !fs_out, "R1 outputs reset", {dac_word, ser_out, fs_out}, 0);

    // write latency and MSB-0 control outside mixed mode
    f0 = frames;
    send(16'h015A, 1'b0);
    chk(reg_clk == 8'h00, "R2 write not yet visible", reg_clk, 8'h00);
    @(negedge clk);
    chk(reg_clk == 8'h5A, "R2 write at latency", reg_clk, 8'h5A);
    idle();
    chk(frames == f0, "R3 write sends nothing", frames, f0);
    chk(reg_clk == 8'h5A, "R6 MSB0 decoded as control", reg_clk, 8'h5A);

    // hop forwarding over every non-zero address
    for (int a = 1; a < 8; a++) begin
      for (int k = 0; k < 3; k++) begin
        w    = {1'b1, 1'b0, 3'(a), 3'(a), d_list[k]};
        snap = {reg_mode, reg_clk, reg_pwr};
        f0   = frames;
        send(w, 1'b0);
        idle();
        chk(frames == f0 + 1, "R4 one word forwarded", frames, f0 + 1);
        chk(last_word == fwd(w), "R4 address decremented", last_word, fwd(w));
        chk(fs_seen - sent_cyc == 19, "R2 output frame timing", fs_seen - sent_cyc, 19);
        chk({reg_mode, reg_clk, reg_pwr} == snap, "R4 registers untouched", {reg_mode, reg_clk, reg_pwr}, snap);
      end
    end
    chk(fs_high == frames, "R2 frame pulse one clock", fs_high, frames);

    // readback
    send(16'h823F, 1'b0);
    idle();
    chk(reg_pwr == 8'h3F, "R3 power write", reg_pwr, 8'h3F);
    for (int s = 0; s < 6; s++) begin
      logic [7:0] v;
      v    = (s == 0) ? 8'h01 : (s == 1) ? 8'h5A : (s == 2) ? 8'h3F : 8'h00;
      w    = {1'b1, 1'b1, 3'b000, 3'(s), 8'h00};
      snap = {reg_mode, reg_clk, reg_pwr};
      send(w, 1'b0);
      idle();
      chk(last_word == {1'b1, 1'b1, 3'b111, 3'(s), v}, "R5 readback word", last_word, {1'b1, 1'b1, 3'b111, 3'(s), v});
      chk({reg_mode, reg_clk, reg_pwr} == snap, "R5 readback changes nothing", {reg_mode, reg_clk, reg_pwr}, snap);
    end
    send(16'hD1C4, 1'b0);
    idle();
    chk(last_word == fwd(16'hD1C4), "R5 remote readback forwarded", last_word, fwd(16'hD1C4));

    // only one mode bit set: still not mixed
    send(16'h8042, 1'b0);
    idle();
    chk(reg_mode == 8'h42, "R6 mode write", reg_mode, 8'h42);
    s0 = strobes; f0 = frames;
    send(16'h0177, 1'b0);
    idle();
    chk(reg_clk == 8'h77, "R6 half mode keeps control decode", reg_clk, 8'h77);
    chk(strobes == s0 && frames == f0, "R6 no DAC activity", strobes - s0, 0);

    // mixed mode, device count 2
    send(16'h80C2, 1'b0);
    idle();
    chk(reg_mode == 8'hC2, "R6 mixed mode entered", reg_mode, 8'hC2);
    s0 = strobes; f0 = frames;
    send(16'h1234, 1'b0);
    idle();
    chk(strobes == s0, "R7 no update on first frame", strobes - s0, 0);
    chk(frames == f0 + 1 && last_word == 16'h0000, "R8 reset held word sent", last_word, 16'h0000);
    send(16'h2345, 1'b0);
    idle();
    chk(strobes == s0 + 1 && dac_word == 16'h2345, "R7 update at count", dac_word, 16'h2345);
    chk(last_word == 16'h1234, "R8 previous DAC word sent", last_word, 16'h1234);

    // control words between DAC frames
    s0 = strobes;
    send(16'h0AAA, 1'b0);
    idle();
    send(16'h820F, 1'b0);
    idle();
    chk(reg_pwr == 8'h0F, "R9 control write in mixed mode", reg_pwr, 8'h0F);
    chk(strobes == s0, "R9 control word not counted", strobes - s0, 0);
    send(16'h0BBB, 1'b0);
    idle();
    chk(strobes == s0 + 1 && dac_word == 16'h0BBB, "R9 update on second DAC frame", dac_word, 16'h0BBB);

    // stray frame pulse mid-word
    f0 = frames;
    send(16'h8166, 1'b1);
    idle();
    chk(reg_clk == 8'h66, "R10 word intact despite pulse", reg_clk, 8'h66);
    chk(frames == f0, "R10 no spurious word", frames, f0);

    // every device count, field 0 meaning eight
    for (int n = 0; n < 8; n++) begin
      int kmax;
      send(16'h80C0 | 16'(n), 1'b0);
      idle();
      kmax = (n == 0) ? 8 : n;
      for (int j = 1; j <= kmax; j++) begin
        w  = 16'(n * 256 + j * 16 + 1);
        s0 = strobes;
        send(w, 1'b0);
        idle();
        chk(strobes == s0 + ((j == kmax) ? 1 : 0), "R7 strobe on count", strobes - s0, (j == kmax) ? 1 : 0);
        if (j == kmax) chk(dac_word == w, "R7 latched word", dac_word, w);
      end
    end

    finish_run();
  end
endmodule